// File: doc/BRIEF.md
# Multithreaded Switch Port Timing Model

This block is the timing half of a simulated output-buffered switch. It does not move payload. It decides, one simulated cycle at a time, when each queued packet leaves its output port and whether a newly arriving packet is rejected for lack of buffer space. The routing is source-based: each arriving descriptor already names its output port, so no forwarding table is involved.

A single update datapath serves every port in turn. A slot counter walks the active ports in round-robin order. In its slot, a port's state is read from thread-indexed storage, advanced by exactly one simulated cycle, and written back. That state is a byte occupancy, a countdown for the packet at the head, and a small FIFO of packet lengths. Link speed (bits per simulated cycle), fixed added latency and per-port buffer size are runtime inputs. The same datapath therefore models slow and fast links by changing configuration values only. A feeder watches `slot_idx` and presents a descriptor for a port during that port's slot.

Top module: `swport_tmodel`

## Requirements
- R1: `slot_idx` starts at 0 and steps by one per clock. After reaching N-1 it returns to 0, where N is `cfg_threads` limited to the range 1..NUM_PORTS (a value of 0 counts as 1).
- R2: A descriptor is taken only when `in_valid` is high and `in_dport` equals `slot_idx`. Any other descriptor has no effect on any port: it causes no drop, no departure and no occupancy.
- R3: The transmit delay of a packet is D = ceil(len*8 / rate) + `cfg_latency`, with a rate of 0 treated as 1 and a result of 0 raised to 1. A packet that reaches the head of its port's queue in visit k departs in visit k+D of that port.
- R4: A packet arriving at an empty port reaches the head in its arrival visit. A queued packet reaches the head in the same visit in which its predecessor departs.
- R5: An arriving packet is dropped when its length would push the port's occupancy above `cfg_buf_bytes`, or when the port already holds QDEPTH packets. A drop sets bit p of `drop_strobe` for one cycle.
- R6: Departures on a port follow arrival order. `dep_len` carries the departing packet's length, and is 0 when nothing departs.
- R7: A departing packet's bytes are released before the same visit's arrival is judged. An arrival that exactly fills the buffer is accepted.
- R8: `dep_strobe` and `drop_strobe` are registered and have at most one bit set. A set bit is always the port of the slot processed at the preceding clock edge.
- R9: After reset, the slot is 0, both strobes are 0, and every port is empty with zero occupancy.
- R10: A configuration change applies to the next packet that reaches a queue head, without reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_threads | input | $clog2(NUM_PORTS+1) | Number of active ports/threads |
| cfg_rate | input | RATE_W | Link speed in bits per simulated cycle (0 means 1) |
| cfg_latency | input | LAT_W | Fixed cycles added to every packet |
| cfg_buf_bytes | input | OCC_W | Per-port buffer limit in bytes |
| in_valid | input | 1 | Descriptor present |
| in_len | input | LEN_W | Packet length in bytes |
| in_dport | input | PORT_W | Destination port carried by the descriptor |
| slot_idx | output | PORT_W | Port whose slot is processed at the next edge |
| dep_strobe | output | NUM_PORTS | One-hot departure pulse |
| dep_len | output | LEN_W | Length of the departing packet |
| drop_strobe | output | NUM_PORTS | One-hot drop pulse |

## Verification
A corrupted countdown or queue pointer shows up the next time its port is served. It appears as an early, late or missing departure pulse, or as a wrong `dep_len`, at most D visits of that port later. A wrong occupancy count stays hidden until a later arrival is close to the buffer limit. Then it appears as a drop pulse that should not occur, or a missing drop pulse. For this reason the bench drives fill-to-exact-limit and same-visit release cases. A slot counter that skips or wraps wrongly is visible on `slot_idx` on the very next cycle.

// File: rtl/swport_pkg.sv
package swport_pkg;
  // Largest number of ports one shared datapath is meant to serve.
  localparam int SWP_MAX_PORTS  = 64;
  // Bytes to bits conversion shift.
  localparam int SWP_BYTE_SHIFT = 3;
endpackage

// File: rtl/swport_slot_seq.sv
module swport_slot_seq #(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 3,
  parameter int TCNT_W    = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [TCNT_W-1:0] cfg_threads,
  output logic [PORT_W-1:0] slot
);
  logic [TCNT_W-1:0] eff_cnt;

  always_comb begin
    if (cfg_threads == '0)
      eff_cnt = TCNT_W'(1);
    else if (cfg_threads > TCNT_W'(NUM_PORTS))
      eff_cnt = TCNT_W'(NUM_PORTS);
    else
      eff_cnt = cfg_threads;
  end

  always_ff @(posedge clk) begin
    if (rst)
      slot <= '0;
    else if (TCNT_W'(slot) + TCNT_W'(1) >= eff_cnt)
      slot <= '0;
    else
      slot <= slot + PORT_W'(1);
  end
endmodule

// File: rtl/swport_delay_calc.sv
module swport_delay_calc
  import swport_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int RATE_W = 8,
  parameter int LAT_W  = 16,
  parameter int DLY_W  = 21
)(
  input  logic [LEN_W-1:0]  len,
  input  logic [RATE_W-1:0] rate,
  input  logic [LAT_W-1:0]  lat,
  output logic [DLY_W-1:0]  delay
);
  localparam int NUM_W = LEN_W + 4;

  logic [NUM_W-1:0] bits, div, quo;
  logic [DLY_W-1:0] sum;

  always_comb begin
    bits  = NUM_W'(len) << SWP_BYTE_SHIFT;
    div   = (rate == '0) ? NUM_W'(1) : NUM_W'(rate);
    quo   = (bits + div - NUM_W'(1)) / div;
    sum   = DLY_W'(quo) + DLY_W'(lat);
    delay = (sum == '0) ? DLY_W'(1) : sum;
  end
endmodule

// File: rtl/swport_len_fifos.sv
module swport_len_fifos #(
  parameter int NUM_PORTS = 8,
  parameter int QDEPTH    = 4,
  parameter int LEN_W     = 16,
  parameter int PORT_W    = 3,
  parameter int QCW       = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] sel,
  input  logic              push,
  input  logic [LEN_W-1:0]  push_len,
  input  logic              pop,
  output logic [LEN_W-1:0]  head_len,
  output logic [LEN_W-1:0]  second_len,
  output logic [QCW-1:0]    count
);
  localparam int QW    = $clog2(QDEPTH);
  localparam int AW    = PORT_W + QW;
  localparam int MEM_N = 1 << AW;

  logic [LEN_W-1:0] mem [MEM_N];
  logic [QW-1:0]    rd_ptr [NUM_PORTS];
  logic [QW-1:0]    wr_ptr [NUM_PORTS];
  logic [QCW-1:0]   fill   [NUM_PORTS];

  logic [QW-1:0] rd_cur, rd_nxt, wr_cur;

  always_comb begin
    rd_cur     = rd_ptr[sel];
    rd_nxt     = rd_cur + QW'(1);
    wr_cur     = wr_ptr[sel];
    head_len   = mem[{sel, rd_cur}];
    second_len = mem[{sel, rd_nxt}];
    count      = fill[sel];
  end

  // Storage write port: no reset, so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push)
      mem[{sel, wr_cur}] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        rd_ptr[i] <= '0;
        wr_ptr[i] <= '0;
        fill[i]   <= '0;
      end
    end else begin
      if (push) wr_ptr[sel] <= wr_cur + QW'(1);
      if (pop)  rd_ptr[sel] <= rd_nxt;
      fill[sel] <= fill[sel] + QCW'(push) - QCW'(pop);
    end
  end
endmodule

// File: rtl/swport_tmodel.sv
module swport_tmodel
  import swport_pkg::*;
#(
  parameter int  NUM_PORTS = 8,
  parameter int  QDEPTH    = 4,
  parameter int  LEN_W     = 16,
  parameter int  LAT_W     = 16,
  parameter int  OCC_W     = 19,
  parameter int  RATE_W    = 8,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int TCNT_W    = $clog2(NUM_PORTS + 1)
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TCNT_W-1:0]    cfg_threads,
  input  logic [RATE_W-1:0]    cfg_rate,
  input  logic [LAT_W-1:0]     cfg_latency,
  input  logic [OCC_W-1:0]     cfg_buf_bytes,
  input  logic                 in_valid,
  input  logic [LEN_W-1:0]     in_len,
  input  logic [PORT_W-1:0]    in_dport,
  output logic [PORT_W-1:0]    slot_idx,
  output logic [NUM_PORTS-1:0] dep_strobe,
  output logic [LEN_W-1:0]     dep_len,
  output logic [NUM_PORTS-1:0] drop_strobe
);
  localparam int QCW    = $clog2(QDEPTH + 1);
  localparam int DLY_W  = ((LEN_W + 4 > LAT_W) ? LEN_W + 4 : LAT_W) + 1;
  localparam int OCC_W1 = OCC_W + 1;

  if (NUM_PORTS < 1 || NUM_PORTS > SWP_MAX_PORTS) begin : g_bad_ports
    $error("swport_tmodel: NUM_PORTS out of range");
  end

  logic [PORT_W-1:0] slot;

  swport_slot_seq #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .TCNT_W(TCNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .cfg_threads(cfg_threads), .slot(slot)
  );

  assign slot_idx = slot;

  // Thread-indexed per-port timing state.
  logic [OCC_W-1:0] occ_q [NUM_PORTS];
  logic [DLY_W-1:0] cnt_q [NUM_PORTS];

  logic [QCW-1:0]   q_cnt;
  logic [LEN_W-1:0] head_len, second_len, load_len;
  logic [DLY_W-1:0] load_delay;
  logic [OCC_W-1:0] occ_cur, occ_after_dep;
  logic [DLY_W-1:0] cnt_cur;
  logic [OCC_W1-1:0] occ_need;
  logic [QCW-1:0]   cnt_after_dep;
  logic             hit, dep, accept, drop, load;

  swport_len_fifos #(
    .NUM_PORTS(NUM_PORTS), .QDEPTH(QDEPTH), .LEN_W(LEN_W),
    .PORT_W(PORT_W), .QCW(QCW)
  ) u_fifos (
    .clk(clk), .rst(rst), .sel(slot),
    .push(accept), .push_len(in_len), .pop(dep),
    .head_len(head_len), .second_len(second_len), .count(q_cnt)
  );

  swport_delay_calc #(
    .LEN_W(LEN_W), .RATE_W(RATE_W), .LAT_W(LAT_W), .DLY_W(DLY_W)
  ) u_delay (
    .len(load_len), .rate(cfg_rate), .lat(cfg_latency), .delay(load_delay)
  );

  // One simulated cycle of the port that owns the current slot.
  always_comb begin
    occ_cur       = occ_q[slot];
    cnt_cur       = cnt_q[slot];
    hit           = in_valid && (in_dport == slot);
    dep           = (q_cnt != '0) && (cnt_cur == DLY_W'(1));
    cnt_after_dep = q_cnt - QCW'(dep);
    occ_after_dep = dep ? (occ_cur - OCC_W'(head_len)) : occ_cur;
    occ_need      = OCC_W1'(occ_after_dep) + OCC_W1'(in_len);
    accept        = hit && (occ_need <= OCC_W1'(cfg_buf_bytes))
                        && (cnt_after_dep < QCW'(QDEPTH));
    drop          = hit && !accept;
    load          = (dep && (cnt_after_dep != '0)) ||
                    ((cnt_after_dep == '0) && accept);
    load_len      = (dep && (cnt_after_dep != '0)) ? second_len : in_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        occ_q[i] <= '0;
        cnt_q[i] <= '0;
      end
      dep_strobe  <= '0;
      drop_strobe <= '0;
      dep_len     <= '0;
    end else begin
      occ_q[slot] <= accept ? (occ_after_dep + OCC_W'(in_len)) : occ_after_dep;
      if (load)
        cnt_q[slot] <= load_delay;
      else if (q_cnt != '0)
        cnt_q[slot] <= cnt_cur - DLY_W'(1);
      dep_strobe  <= dep  ? (NUM_PORTS'(1) << slot) : '0;
      drop_strobe <= drop ? (NUM_PORTS'(1) << slot) : '0;
      dep_len     <= dep  ? head_len : '0;
    end
  end
endmodule

// File: rtl/swport_tmodel_chk.sv
module swport_tmodel_chk #(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 3,
  parameter int LEN_W     = 16
)(
  input logic                 clk,
  input logic                 rst,
  input logic [PORT_W-1:0]    slot_idx,
  input logic [NUM_PORTS-1:0] dep_strobe,
  input logic [LEN_W-1:0]     dep_len,
  input logic [NUM_PORTS-1:0] drop_strobe
);
  always_comb begin
    if (rst == 1'b0)
      a_slot_range_r1: assert (32'(slot_idx) < NUM_PORTS);
  end

  p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
    (slot_idx != '0) |=> ((slot_idx == $past(slot_idx) + PORT_W'(1)) || (slot_idx == '0)));

  p_dep_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dep_strobe) && $onehot0(drop_strobe));

  p_dep_slot_r8: assert property (@(posedge clk) disable iff (rst)
    (dep_strobe != '0) |-> (dep_strobe == (NUM_PORTS'(1) << $past(slot_idx))));

  p_drop_slot_r5: assert property (@(posedge clk) disable iff (rst)
    (drop_strobe != '0) |-> (drop_strobe == (NUM_PORTS'(1) << $past(slot_idx))));

  p_len_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (dep_strobe == '0) |-> (dep_len == '0));

  p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ((slot_idx == '0) && (dep_strobe == '0) && (drop_strobe == '0)));
endmodule

bind swport_tmodel swport_tmodel_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .slot_idx(slot_idx), .dep_strobe(dep_strobe),
  .dep_len(dep_len), .drop_strobe(drop_strobe)
);

// File: tb/swport_tmodel_bench.sv
module swport_tmodel_bench;
  localparam int NP = 8;
  localparam int QD = 4;

  logic        clk = 1'b0;
  always #10 clk = ~clk; // 20 ns period, 50 MHz

  logic        rst;
  logic [3:0]  cfg_threads;
  logic [7:0]  cfg_rate;
  logic [15:0] cfg_latency;
  logic [18:0] cfg_buf_bytes;
  logic        in_valid;
  logic [15:0] in_len;
  logic [2:0]  in_dport;
  logic [2:0]  slot_idx;
  logic [NP-1:0] dep_strobe, drop_strobe;
  logic [15:0] dep_len;

  swport_tmodel u_swport_tmodel (
    .clk(clk), .rst(rst), .cfg_threads(cfg_threads), .cfg_rate(cfg_rate),
    .cfg_latency(cfg_latency), .cfg_buf_bytes(cfg_buf_bytes),
    .in_valid(in_valid), .in_len(in_len), .in_dport(in_dport),
    .slot_idx(slot_idx), .dep_strobe(dep_strobe), .dep_len(dep_len),
    .drop_strobe(drop_strobe)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Reference state built from the requirements.
  int          m_slot;
  int unsigned m_occ [NP];
  int unsigned m_cnt [NP];
  int unsigned m_q   [NP][$];

  function automatic int unsigned f_delay(int unsigned len, int unsigned rate, int unsigned lat);
    int unsigned r = (rate == 0) ? 1 : rate;
    int unsigned t = (len * 8 + r - 1) / r + lat;
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int f_next_slot(int s);
    int eff = (cfg_threads == 0) ? 1 : ((cfg_threads > NP) ? NP : int'(cfg_threads));
    return (s + 1 >= eff) ? 0 : s + 1;
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic model_clear();
    m_slot = 0;
    for (int i = 0; i < NP; i++) begin
      m_occ[i] = 0; m_cnt[i] = 0; m_q[i].delete();
    end
  endtask

  // One host cycle: drive at negedge, predict, let one edge pass, compare.
  task automatic cycle(bit v, int unsigned l, int unsigned d);
    logic [NP-1:0] e_dep  = '0;
    logic [NP-1:0] e_drop = '0;
    int unsigned   e_len  = 0;
    int  s = m_slot;
    bit  departed = 0;
    bit  was_empty = (m_q[s].size() == 0);
    int  nxt;
    in_valid = v; in_len = 16'(l); in_dport = 3'(d);
    if (m_q[s].size() != 0) begin
      if (m_cnt[s] == 1) begin
        e_dep[s] = 1'b1; e_len = m_q[s][0];
        m_occ[s] -= m_q[s][0];
        void'(m_q[s].pop_front());
        departed = 1;
      end else m_cnt[s]--;
    end
    if (v && (d == s)) begin
      if ((m_occ[s] + l <= cfg_buf_bytes) && (m_q[s].size() < QD)) begin
        m_q[s].push_back(l); m_occ[s] += l;
      end else e_drop[s] = 1'b1;
    end
    if ((departed || was_empty) && m_q[s].size() != 0)
      m_cnt[s] = f_delay(m_q[s][0], cfg_rate, cfg_latency);
    nxt = f_next_slot(s);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 slot order", slot_idx, nxt);
    chk("R3 R4 departure strobe", dep_strobe, e_dep);
    chk("R5 drop strobe", drop_strobe, e_drop);
    chk("R6 departure length", dep_len, e_len);
    m_slot = nxt;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    chk("R9 reset slot", slot_idx, 0);
    chk("R9 reset departure", dep_strobe, 0);
    chk("R9 reset drop", drop_strobe, 0);
  endtask

  task automatic wait_dep(int port, output int n);
    n = 0;
    do begin
      cycle(0, 0, 0);
      n++;
    end while (!dep_strobe[port] && n < 2000);
  endtask

  int n;

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; in_len = '0; in_dport = '0;
    cfg_threads = 4'd1; cfg_rate = 8'd8; cfg_latency = 16'd2; cfg_buf_bytes = 19'd1000;
    @(negedge clk);
    do_reset();

    // R3: single packet, 16 bytes at 8 bits/cycle plus 2 -> 18 visits
    cycle(1, 16, 0);
    wait_dep(0, n);
    chk("R3 delay len16 rate8 lat2", n, 18);
    chk("R6 length of departure", dep_len, 16);

    // R3: rate 0 acts as 1 -> 2 bytes = 16 visits
    cfg_rate = 8'd0; cfg_latency = 16'd0;
    cycle(1, 2, 0);
    wait_dep(0, n);
    chk("R3 rate zero treated as one", n, 16);

    // R4 R6: back-to-back, second loaded at first departure
    cfg_rate = 8'd8;
    cycle(1, 4, 0);
    cycle(1, 8, 0);
    wait_dep(0, n);
    chk("R4 first departure", n, 3);
    chk("R6 first length", dep_len, 4);
    wait_dep(0, n);
    chk("R4 gap equals second delay", n, 8);
    chk("R6 second length in order", dep_len, 8);

    // R10: runtime rate change applies to next head packet
    cfg_rate = 8'd64;
    cycle(1, 8, 0);
    wait_dep(0, n);
    chk("R10 new rate one visit", n, 1);

    // R5: fill exactly, then overflow by one byte
    do_reset();
    cfg_buf_bytes = 19'd100; cfg_rate = 8'd8; cfg_latency = 16'd50;
    cycle(1, 60, 0);
    cycle(1, 40, 0);
    chk("R5 exact fill accepted", drop_strobe, 0);
    cycle(1, 1, 0);
    chk("R5 overflow dropped", drop_strobe, 1);

    // R5: queue depth limit
    do_reset();
    cfg_buf_bytes = 19'd1000;
    for (int i = 0; i < QD; i++) cycle(1, 1, 0);
    cycle(1, 1, 0);
    chk("R5 queue full dropped", drop_strobe, 1);

    // R7: bytes released in the departure visit before arrival judged
    do_reset();
    cfg_buf_bytes = 19'd100; cfg_rate = 8'd200; cfg_latency = 16'd0;
    cycle(1, 100, 0);
    repeat (3) cycle(0, 0, 0);
    cycle(1, 100, 0);
    chk("R7 departure in same visit", dep_strobe, 1);
    chk("R7 arrival accepted after release", drop_strobe, 0);

    // R2: descriptor outside its slot is ignored
    do_reset();
    cfg_threads = 4'd4; cfg_buf_bytes = 19'd50; cfg_rate = 8'd8; cfg_latency = 16'd0;
    cycle(1, 50, 2);          // slot 0, port 2 named: ignored
    chk("R2 mismatched descriptor no drop", drop_strobe, 0);
    cycle(0, 0, 0);           // slot 1
    cycle(1, 50, 2);          // slot 2: would overflow if first had counted
    chk("R2 occupancy untouched", drop_strobe, 0);
    repeat (8) cycle(0, 0, 0);

    // R1: thread count clamps
    cfg_threads = 4'd0;
    repeat (4) cycle(0, 0, 0);
    chk("R1 zero threads stays at slot 0", slot_idx, 0);
    cfg_threads = 4'd15;
    repeat (20) cycle(0, 0, 0);

    // Random traffic across all ports
    do_reset();
    cfg_threads = 4'(NP);
    for (int blk = 0; blk < 8; blk++) begin
      cfg_rate      = 8'($urandom_range(40, 0));
      cfg_latency   = 16'($urandom_range(6, 0));
      cfg_buf_bytes = 19'($urandom_range(300, 20));
      for (int k = 0; k < 500; k++) begin
        bit v = ($urandom % 3) != 0;
        int unsigned d = (($urandom % 5) == 0) ? ($urandom % NP) : m_slot;
        cycle(v, 1 + ($urandom % 64), d);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule